// File: doc/BRIEF.md
# Event Breakpoint Sequence Checker

This block watches the memory accesses of a processor and compares them with a programmed, ordered chain of event breakpoints that together describe the path the code is expected to take. Each breakpoint names an access function (a function identifier carried on the monitor bus), an access value, and the largest number of clock cycles that may pass since the previous matched breakpoint. The chain is walked one entry at a time. A match moves the checker to the next entry, until the programmed final entry is matched and the run is declared complete.

When an access from the expected function departs from the chain, either with a wrong value or too late, the checker stores one snapshot of that access in a trace buffer and freezes until software acknowledges it. An entry can also be marked as a forbidden node. Reaching it is logged the same way as a departure. Accesses from functions that the current entry does not name are ignored, so unrelated code may run between events. Comparison and sequencing are done entirely in hardware.

Top module: `evtrail_checker`

## Requirements
- R1: After reset, seq_state is 0 (idle), cur_idx is 0, done and fault are 0, trc_count is 0 and trc_overflow is 0.
- R2: A start pulse in idle moves seq_state to 1 (armed) with cur_idx 0 and the elapsed count cleared. Start in any other state has no effect, and monitor accesses in idle change nothing.
- R3: In armed (1) or tracking (2), an access whose function and value equal those of the current valid, non-forbidden entry, within its time limit, is a match. The first match moves the state to tracking. A match on a non-final entry increments cur_idx by one.
- R4: The elapsed count is cleared by start and by every match. It rises by one on every other active cycle, including cycles with ignored accesses, and saturates at its all-ones value. A match needs elapsed count <= the entry's limit. An access that is otherwise matching but later than the limit is a departure.
- R5: A match on the entry whose index equals the final-node register moves seq_state to 3 (done) and raises done. No snapshot is written.
- R6: An access whose function differs from the current entry's function is ignored: state, cur_idx and the trace are unchanged.
- R7: A departure (same function, different value, or late) moves seq_state to 4 (fault) and raises fault. It writes one snapshot with bits [35:32] the current index, [31:24] the access function, [23:16] the access value and [15:0] the elapsed count.
- R8: A match on an entry marked forbidden is a fault, logged exactly as in R7, not progress.
- R9: In done or fault, monitor accesses change nothing and write no snapshot. An ack pulse returns the checker to idle with cur_idx 0 and clears done and fault.
- R10: The trace buffer holds TRACE_DEPTH snapshots. When it is full, a further snapshot is dropped, trc_count stays at TRACE_DEPTH and trc_overflow rises and stays set.
- R11: trc_rdata presents the snapshot stored at trc_raddr one clock after the address is applied. Snapshots are stored in the order they occur, starting at address 0.
- R12: A cfg_we write stores cfg_wdata at entry cfg_addr with layout bit 33 valid, bit 32 forbidden, [31:24] function, [23:16] value, [15:0] cycle limit. A final_we write loads the final-node index.
- R13: An entry whose valid bit is 0 matches nothing. Every access while it is the current entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm the chain from entry 0 (idle only) |
| ack | input | 1 | Return from done or fault to idle |
| cfg_we | input | 1 | Breakpoint entry write strobe |
| cfg_addr | input | 4 | Entry index to write |
| cfg_wdata | input | 34 | Entry contents {valid, forbidden, function, value, limit} |
| final_we | input | 1 | Final-node index write strobe |
| final_idx_in | input | 4 | Final-node index |
| mon_valid | input | 1 | Monitored access present this cycle |
| mon_func | input | 8 | Function identifier of the access |
| mon_value | input | 8 | Value of the access |
| trc_raddr | input | 10 | Trace read address |
| trc_rdata | output | 36 | Snapshot read data, one cycle after the address |
| trc_count | output | 11 | Number of stored snapshots |
| trc_overflow | output | 1 | A snapshot was dropped because the buffer was full |
| seq_state | output | 3 | 0 idle, 1 armed, 2 tracking, 3 done, 4 fault |
| cur_idx | output | 4 | Index of the expected entry |
| done | output | 1 | Final node matched |
| fault | output | 1 | Departure or forbidden node hit |

## Verification
The assertions assume that the final-node register is not lowered below the current index while a run is active, and that start and ack are single-cycle pulses applied while the monitor bus is idle. The stimulus programs the table and the final index only before a run starts or while the checker waits on entry 0. It drives each access for exactly one cycle from the falling edge, so the elapsed count an access sees equals the number of cycles the bench let pass since the last match. The bench also shrinks the trace buffer to four entries so that the full-buffer case can be reached in a few runs.

// File: rtl/evtrail_pkg.sv
package evtrail_pkg;

    localparam int FUNC_W    = 8;
    localparam int VAL_W     = 8;
    localparam int ELAPSED_W = 16;
    localparam int ENTRY_W   = 2 + FUNC_W + VAL_W + ELAPSED_W;

    typedef struct packed {
        logic                 valid;
        logic                 forbidden;
        logic [FUNC_W-1:0]    func;
        logic [VAL_W-1:0]     value;
        logic [ELAPSED_W-1:0] max_gap;
    } bp_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_TRACK = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        V_IGNORE  = 2'd0,
        V_ADVANCE = 2'd1,
        V_DEVIATE = 2'd2,
        V_FORBID  = 2'd3
    } verdict_t;

    function automatic logic [ELAPSED_W-1:0] sat_inc(input logic [ELAPSED_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic logic is_active(input seq_state_t s);
        return (s == ST_ARMED) || (s == ST_TRACK);
    endfunction

endpackage

// File: rtl/evtrail_bp_table.sv
module evtrail_bp_table
    import evtrail_pkg::*;
#(
    parameter int NUM_BP = 16,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  bp_entry_t        wr_entry,
    input  logic             final_we,
    input  logic [IDX_W-1:0] final_in,
    input  logic [IDX_W-1:0] rd_idx,
    output bp_entry_t        rd_entry,
    output logic [IDX_W-1:0] final_idx
);

    bp_entry_t        table_q [NUM_BP];
    logic [IDX_W-1:0] final_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BP; i++) begin
                table_q[i] <= '0;
            end
            final_q <= '0;
        end else begin
            if (wr_en) begin
                table_q[wr_addr] <= wr_entry;
            end
            if (final_we) begin
                final_q <= final_in;
            end
        end
    end

    assign rd_entry  = table_q[rd_idx];
    assign final_idx = final_q;

    // R12: a written entry is visible on the next cycle when selected
    assert_entry_write_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == rd_idx)) |=> (($past(rd_idx) != rd_idx) || (rd_entry == $past(wr_entry))));

endmodule

// File: rtl/evtrail_matcher.sv
module evtrail_matcher
    import evtrail_pkg::*;
(
    input  logic                 active,
    input  logic                 mon_valid,
    input  logic [FUNC_W-1:0]    mon_func,
    input  logic [VAL_W-1:0]     mon_value,
    input  bp_entry_t            expected,
    input  logic [ELAPSED_W-1:0] elapsed,
    output verdict_t             verdict
);

    logic same_func;
    logic same_value;
    logic in_time;

    assign same_func  = expected.valid && (mon_func == expected.func);
    assign same_value = (mon_value == expected.value);
    assign in_time    = (elapsed <= expected.max_gap);

    always_comb begin
        verdict = V_IGNORE;
        if (active && mon_valid && same_func) begin
            if (same_value && in_time) begin
                verdict = expected.forbidden ? V_FORBID : V_ADVANCE;
            end else begin
                verdict = V_DEVIATE;
            end
        end
    end

    // R13 / R6: an entry without its valid bit never produces a verdict
    always_comb begin
        if (!expected.valid) begin
            assert_unprogrammed_quiet_R13: assert (verdict == V_IGNORE);
        end
    end

endmodule

// File: rtl/evtrail_seq.sv
module evtrail_seq
    import evtrail_pkg::*;
#(
    parameter int NUM_BP = 16,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 ack,
    input  verdict_t             verdict,
    input  logic [IDX_W-1:0]     final_idx,
    output seq_state_t           state,
    output logic [IDX_W-1:0]     cur_idx,
    output logic [ELAPSED_W-1:0] elapsed,
    output logic                 log_en
);

    seq_state_t           state_q;
    logic [IDX_W-1:0]     idx_q;
    logic [ELAPSED_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_ARMED;
                        idx_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_ARMED, ST_TRACK: begin
                    cnt_q <= sat_inc(cnt_q);
                    case (verdict)
                        V_ADVANCE: begin
                            cnt_q <= '0;
                            if (idx_q == final_idx) begin
                                state_q <= ST_DONE;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                state_q <= ST_TRACK;
                            end
                        end
                        V_DEVIATE, V_FORBID: begin
                            state_q <= ST_FAULT;
                        end
                        default: begin
                        end
                    endcase
                end
                ST_DONE, ST_FAULT: begin
                    if (ack) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state   = state_q;
    assign cur_idx = idx_q;
    assign elapsed = cnt_q;
    assign log_en  = (verdict == V_DEVIATE) || (verdict == V_FORBID);

    // R3: a match on a non-final entry steps the index by one and clears the count
    assert_step_on_match_R3: assert property (@(posedge clk) disable iff (rst)
        (is_active(state_q) && verdict == V_ADVANCE && idx_q != final_idx)
        |=> (idx_q == $past(idx_q) + 1'b1) && (cnt_q == '0) && (state_q == ST_TRACK));

    // R5: a match on the final entry ends the run
    assert_final_done_R5: assert property (@(posedge clk) disable iff (rst)
        (is_active(state_q) && verdict == V_ADVANCE && idx_q == final_idx) |=> (state_q == ST_DONE));

    // R6: ignored accesses leave the position untouched
    assert_ignore_keeps_pos_R6: assert property (@(posedge clk) disable iff (rst)
        (is_active(state_q) && verdict == V_IGNORE) |=> ($stable(idx_q) && is_active(state_q)));

    // R4: the count saturates instead of wrapping
    assert_count_saturates_R4: assert property (@(posedge clk) disable iff (rst)
        (is_active(state_q) && (&cnt_q) && verdict == V_IGNORE) |=> (&cnt_q));

    // R9: fault is frozen until acknowledged
    assert_fault_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT && !ack) |=> (state_q == ST_FAULT) && $stable(idx_q) && $stable(cnt_q));

    // R2: start outside idle has no effect on a completed run
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !ack) |=> (state_q == ST_DONE));

endmodule

// File: rtl/evtrail_trace.sv
module evtrail_trace #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    output logic [AW:0]      count,
    output logic             overflow
);

    localparam logic [AW:0] CAP = (AW + 1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      cnt_q;
    logic             ovf_q;
    logic             full;

    assign full = (cnt_q == CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[cnt_q[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

    assign count    = cnt_q;
    assign overflow = ovf_q;

    // R10: a full buffer never wraps
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (count == CAP) |=> (count == CAP));

    // R10: overflow is sticky
    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: the fill level moves only on a snapshot write
    assert_one_per_write_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(count));

endmodule

// File: rtl/evtrail_checker.sv
module evtrail_checker
    import evtrail_pkg::*;
#(
    parameter int NUM_BP      = 16,
    parameter int TRACE_DEPTH = 1024,
    localparam int IDX_W      = $clog2(NUM_BP),
    localparam int TAW        = $clog2(TRACE_DEPTH),
    localparam int SNAP_W     = IDX_W + FUNC_W + VAL_W + ELAPSED_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ack,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic              final_we,
    input  logic [IDX_W-1:0]  final_idx_in,
    input  logic              mon_valid,
    input  logic [FUNC_W-1:0] mon_func,
    input  logic [VAL_W-1:0]  mon_value,
    input  logic [TAW-1:0]    trc_raddr,
    output logic [SNAP_W-1:0] trc_rdata,
    output logic [TAW:0]      trc_count,
    output logic              trc_overflow,
    output logic [2:0]        seq_state,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              done,
    output logic              fault
);

    bp_entry_t            cfg_entry;
    bp_entry_t            expected;
    logic [IDX_W-1:0]     final_idx;
    seq_state_t           state;
    logic [IDX_W-1:0]     idx;
    logic [ELAPSED_W-1:0] elapsed;
    verdict_t             verdict;
    logic                 log_en;
    logic [SNAP_W-1:0]    snapshot;

    assign cfg_entry = bp_entry_t'(cfg_wdata);

    evtrail_bp_table #(.NUM_BP(NUM_BP)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_entry (cfg_entry),
        .final_we (final_we),
        .final_in (final_idx_in),
        .rd_idx   (idx),
        .rd_entry (expected),
        .final_idx(final_idx)
    );

    evtrail_matcher u_match (
        .active   (is_active(state)),
        .mon_valid(mon_valid),
        .mon_func (mon_func),
        .mon_value(mon_value),
        .expected (expected),
        .elapsed  (elapsed),
        .verdict  (verdict)
    );

    evtrail_seq #(.NUM_BP(NUM_BP)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ack      (ack),
        .verdict  (verdict),
        .final_idx(final_idx),
        .state    (state),
        .cur_idx  (idx),
        .elapsed  (elapsed),
        .log_en   (log_en)
    );

    assign snapshot = {idx, mon_func, mon_value, elapsed};

    evtrail_trace #(.DEPTH(TRACE_DEPTH), .WIDTH(SNAP_W)) u_trace (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (log_en),
        .wr_data (snapshot),
        .raddr   (trc_raddr),
        .rdata   (trc_rdata),
        .count   (trc_count),
        .overflow(trc_overflow)
    );

    assign seq_state = state;
    assign cur_idx   = idx;
    assign done      = (state == ST_DONE);
    assign fault     = (state == ST_FAULT);

    // R7 / R8: entering fault is always accompanied by a snapshot attempt
    assert_fault_logged_R7: assert property (@(posedge clk) disable iff (rst)
        (is_active(state) && log_en) |=> (fault && (trc_overflow || trc_count != $past(trc_count))));

    // R9: nothing is logged while done or fault
    assert_quiet_when_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |=> (!$past(log_en) && (!fault || $stable(trc_count) || $past(!fault))));

endmodule

// File: tb/sim_evtrail_checker.sv
module sim_evtrail_checker;
    import evtrail_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NBP        = 16;
    localparam int TDEPTH     = 4;
    localparam int IW         = $clog2(NBP);
    localparam int TAW        = $clog2(TDEPTH);
    localparam int SW         = IW + FUNC_W + VAL_W + ELAPSED_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ack = 1'b0;
    logic cfg_we = 1'b0;
    logic final_we = 1'b0;
    logic mon_valid = 1'b0;
    logic [IW-1:0]      cfg_addr = '0;
    logic [IW-1:0]      final_idx_in = '0;
    logic [ENTRY_W-1:0] cfg_wdata = '0;
    logic [FUNC_W-1:0]  mon_func = '0;
    logic [VAL_W-1:0]   mon_value = '0;
    logic [TAW-1:0]     trc_raddr = '0;
    logic [SW-1:0]      trc_rdata;
    logic [TAW:0]       trc_count;
    logic               trc_overflow;
    logic [2:0]         seq_state;
    logic [IW-1:0]      cur_idx;
    logic               done;
    logic               fault;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [SW-1:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    evtrail_checker #(.NUM_BP(NBP), .TRACE_DEPTH(TDEPTH)) u0 (
        .clk(clk), .rst(rst), .start(start), .ack(ack),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .final_we(final_we), .final_idx_in(final_idx_in),
        .mon_valid(mon_valid), .mon_func(mon_func), .mon_value(mon_value),
        .trc_raddr(trc_raddr), .trc_rdata(trc_rdata), .trc_count(trc_count),
        .trc_overflow(trc_overflow), .seq_state(seq_state), .cur_idx(cur_idx),
        .done(done), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // all drive tasks start and end on a falling edge
    task automatic wr_entry(input int i, input bit v, input bit forb,
                            input int f, input int val, input int lim);
        cfg_we = 1'b1;
        cfg_addr = IW'(i);
        cfg_wdata = {v, forb, FUNC_W'(f), VAL_W'(val), ELAPSED_W'(lim)};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_final(input int i);
        final_we = 1'b1;
        final_idx_in = IW'(i);
        @(negedge clk);
        final_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic access(input int f, input int v);
        mon_valid = 1'b1;
        mon_func = FUNC_W'(f);
        mon_value = VAL_W'(v);
        @(negedge clk);
        mon_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_snap(input int i, input int f, input int v, input int el);
        exp_q.push_back({IW'(i), FUNC_W'(f), VAL_W'(v), ELAPSED_W'(el)});
    endtask

    task automatic chk_pos(input string req, input int st, input int ix);
        chk(seq_state == 3'(st), req, "state", longint'(seq_state), longint'(st));
        chk(cur_idx == IW'(ix), req, "index", longint'(cur_idx), longint'(ix));
    endtask

    // monitor: pops the scoreboard each time a new snapshot appears
    initial begin : monitor
        int seen;
        seen = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            if (int'(trc_count) > seen) begin
                logic [SW-1:0] exp;
                trc_raddr = TAW'(seen);
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected snapshot", longint'(trc_rdata), 0);
                end else begin
                    exp = exp_q.pop_front();
                    chk(trc_rdata == exp, "R11", "snapshot word", longint'(trc_rdata), longint'(exp));
                end
                seen++;
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_pos("R1", 0, 0);
        chk(done == 1'b0 && fault == 1'b0, "R1", "flags", longint'({done, fault}), 0);
        chk(trc_count == '0, "R1", "trace count", longint'(trc_count), 0);
        chk(trc_overflow == 1'b0, "R1", "overflow", longint'(trc_overflow), 0);

        // R12: program the chain
        wr_entry(0, 1, 0, 8'h01, 8'h10, 5);
        wr_entry(1, 1, 0, 8'h02, 8'h20, 3);
        wr_entry(2, 1, 0, 8'h01, 8'h30, 10);
        wr_entry(3, 1, 1, 8'h03, 8'h40, 2);
        set_final(2);

        // R2: accesses in idle change nothing
        access(8'h01, 8'h10);
        chk_pos("R2 idle access", 0, 0);
        pulse_start();
        chk_pos("R2 start", 1, 0);

        // R3: first match
        access(8'h01, 8'h10);
        chk_pos("R3 first match", 2, 1);

        // R6: other function ignored
        access(8'h07, 8'h99);
        chk_pos("R6 other func", 2, 1);
        chk(trc_count == '0, "R6", "trace untouched", longint'(trc_count), 0);

        // R4: elapsed exactly at the limit (ignored access + 2 idle = 3)
        idle(2);
        access(8'h02, 8'h20);
        chk_pos("R4 at limit", 2, 2);

        // R5: final node
        access(8'h01, 8'h30);
        chk_pos("R5 final", 3, 2);
        chk(done == 1'b1, "R5", "done flag", longint'(done), 1);

        // R2: start outside idle ignored; R9: ack returns to idle
        pulse_start();
        chk_pos("R2 start in done", 3, 2);
        access(8'h01, 8'h10);
        chk_pos("R9 access in done", 3, 2);
        pulse_ack();
        chk_pos("R9 ack", 0, 0);
        chk(done == 1'b0, "R9", "done cleared", longint'(done), 0);

        // R4 / R7: late access (4 > 3)
        pulse_start();
        access(8'h01, 8'h10);
        idle(4);
        expect_snap(1, 8'h02, 8'h20, 4);
        access(8'h02, 8'h20);
        chk_pos("R4 late", 4, 1);
        chk(fault == 1'b1, "R7", "fault flag", longint'(fault), 1);

        // R9: frozen in fault
        access(8'h02, 8'h20);
        access(8'h01, 8'h55);
        idle(2);
        chk_pos("R9 frozen", 4, 1);
        chk(trc_count == (TAW + 1)'(1), "R9", "no extra snapshot", longint'(trc_count), 1);
        pulse_ack();
        chk_pos("R9 ack fault", 0, 0);

        // R7: value mismatch on entry 0
        pulse_start();
        expect_snap(0, 8'h01, 8'h11, 0);
        access(8'h01, 8'h11);
        chk_pos("R7 wrong value", 4, 0);
        pulse_ack();

        // R8: forbidden node reached
        set_final(3);
        pulse_start();
        access(8'h01, 8'h10);
        access(8'h02, 8'h20);
        access(8'h01, 8'h30);
        expect_snap(3, 8'h03, 8'h40, 0);
        access(8'h03, 8'h40);
        chk_pos("R8 forbidden", 4, 3);
        chk(done == 1'b0, "R8", "not done", longint'(done), 0);
        pulse_ack();

        // R10: fill then overflow
        pulse_start();
        expect_snap(0, 8'h01, 8'h12, 0);
        access(8'h01, 8'h12);
        idle(3);
        chk(trc_count == (TAW + 1)'(TDEPTH), "R10", "full count", longint'(trc_count), TDEPTH);
        chk(trc_overflow == 1'b0, "R10", "no overflow yet", longint'(trc_overflow), 0);
        pulse_ack();
        pulse_start();
        access(8'h01, 8'h13);
        idle(3);
        chk(trc_count == (TAW + 1)'(TDEPTH), "R10", "count held", longint'(trc_count), TDEPTH);
        chk(trc_overflow == 1'b1, "R10", "overflow set", longint'(trc_overflow), 1);
        chk_pos("R10 fault still raised", 4, 0);
        pulse_ack();

        // R13: unprogrammed entry matches nothing
        wr_entry(0, 0, 0, 8'h01, 8'h10, 5);
        pulse_start();
        access(8'h01, 8'h10);
        access(8'h01, 8'h77);
        chk_pos("R13 unprogrammed", 1, 0);
        wr_entry(0, 1, 0, 8'h01, 8'h10, 100);
        access(8'h01, 8'h10);
        chk_pos("R13 reprogrammed", 2, 1);

        idle(4);
        chk(exp_q.size() == 0, "R11", "scoreboard drained", longint'(exp_q.size()), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule